// File: doc/BRIEF.md
# Extended DMA Address Composer

This block forms the full 64-bit address of each block-move DMA transfer and keeps the transfer counters up to date as data chunks move. A load pulse accepts a new move. The move is either a table-indirect entry or a plain count. For a table-indirect entry, the first entry dword supplies the 24-bit byte count and, depending on the addressing mode, the source of the upper address word. The low address word comes in on its own input.

A 2-bit mode input selects how the upper 32 address bits are built. In table-indirect 64-bit mode, a 5-bit selector in the entry picks a word from a bank of sixteen scratch words and six special words. When the 64-bit timing bit is also set, the block works in 40-bit mode instead: the top byte of the entry is used directly as address bits 39:32. When table-indirect 64-bit mode is off, the upper word comes from a priority chain: the dynamic block-move word, then the static block-move word, then zero.

Each chunk-done pulse carries the length of data that is available. The block moves the smaller of that length and the remaining count. It subtracts this amount from the remaining count and adds it to the low address and to a running byte total.

Top module: `dma_xaddr_top`

## Requirements
- R1: After reset the remaining count, low address, running total and latched upper word are zero, err_o is low and done_o is high.
- R2: A load with tbl_ind_i high takes the remaining count from dw0_i[23:0]. A load with tbl_ind_i low takes it from cnt_ld_i. Both take the low address from lo_addr_i. All of these are visible the cycle after the load.
- R3: On a table-indirect load with mode_i == 2'b11 (40-bit), the latched upper word is {24'b0, dw0_i[31:24]} and err_o stays low, whatever bits 28:24 hold.
- R4: On a table-indirect load with mode_i == 2'b01, a selector dw0_i[28:24] in 0..15 latches scratch word sel, taken from scr_bank_i[sel*32 +: 32].
- R5: A selector in 16..21 latches special word sel-16, taken from spc_bank_i[(sel-16)*32 +: 32]. Word 4 is the static block-move word and word 5 is the dynamic block-move word.
- R6: A selector above 21 latches zero and raises err_o. err_o stays high until the next load.
- R7: A load with tbl_ind_i low, or with mode_i[0] low, latches zero as the upper word and clears err_o.
- R8: While mode_i[0] is high, dma_addr_o[63:32] equals the latched upper word.
- R9: While mode_i[0] is low, dma_addr_o[63:32] is the dynamic word if that word is nonzero, otherwise the static word if that is nonzero, otherwise zero. dma_addr_o[31:0] always equals nxt_addr_o.
- R10: A chunk_i pulse moves len = min(remaining, avail_i). One cycle later, the remaining count drops by len and the low address and running total both rise by len.
- R11: done_o is high when the remaining count is zero. A chunk at zero count changes nothing.
- R12: When a load and a chunk arrive in the same cycle, the load wins and the chunk is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | [0] table-indirect 64-bit enable, [1] 64-bit timing mode |
| start_i | input | 1 | Load a new move |
| tbl_ind_i | input | 1 | The load is a table-indirect entry |
| dw0_i | input | 32 | First table-entry dword |
| lo_addr_i | input | 32 | Low address word for the load |
| cnt_ld_i | input | 24 | Byte count for a load that is not table-indirect |
| scr_bank_i | input | 512 | Sixteen 32-bit scratch words, word 0 in the low bits |
| spc_bank_i | input | 192 | Six 32-bit special words |
| chunk_i | input | 1 | A chunk completes |
| avail_i | input | 24 | Data length available for this chunk |
| dma_addr_o | output | 64 | Composed address of the current chunk |
| chunk_len_o | output | 24 | Length the next chunk would move |
| cnt_o | output | 24 | Remaining byte count |
| nxt_addr_o | output | 32 | Low address word |
| csbc_o | output | 32 | Running byte total |
| done_o | output | 1 | Remaining count is zero |
| err_o | output | 1 | Last load used an illegal selector |

## Verification
The bench targets the edges of the selector range: 15 and 16, and 21 and 22. A decoder that is off by one at any of these edges would return the wrong bank word there, or would raise or miss the error flag. It also loads an entry whose selector bits are illegal while the block is in 40-bit mode. A design that checked the table-indirect bit before the 40-bit combination would then flag an error and lose the top byte. Further cases clip a chunk against a smaller remaining count, send a chunk at zero count, and send a load and a chunk in the same cycle. These catch a design that takes the wrong minimum, lets the count wrap or lets the chunk win. Toggling the mode after a load shows whether the upper word switches between the latched value and the dynamic/static priority chain.

// File: rtl/xaddr_pkg.sv
package xaddr_pkg;
  localparam int ENTRY_W = 32;
  localparam int SEL_W   = 5;
  localparam int SPC_N   = 6;
  localparam int SPC_STAT = 4;
  localparam int SPC_DYN  = 5;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_TI64  = 2'b01,
    MODE_TIME  = 2'b10,
    MODE_A40   = 2'b11
  } xaddr_mode_e;
endpackage

// File: rtl/xaddr_sel.sv
module xaddr_sel #(
  parameter int DW    = 32,
  parameter int SCR_N = 16
) (
  input  logic [xaddr_pkg::SEL_W-1:0]    sel_i,
  input  logic [SCR_N*DW-1:0]            scr_i,
  input  logic [xaddr_pkg::SPC_N*DW-1:0] spc_i,
  output logic [DW-1:0]                  val_o,
  output logic                           bad_o
);
  localparam int TOT_N = SCR_N + xaddr_pkg::SPC_N;

  logic [DW-1:0] bank [TOT_N];

  for (genvar g = 0; g < TOT_N; g++) begin : g_bank
    if (g < SCR_N) begin : g_scr
      assign bank[g] = scr_i[g*DW +: DW];
    end else begin : g_spc
      assign bank[g] = spc_i[(g-SCR_N)*DW +: DW];
    end
  end

  always_comb begin
    val_o = '0;
    bad_o = 1'b1;
    for (int k = 0; k < TOT_N; k++) begin
      if (int'(sel_i) == k) begin
        val_o = bank[k];
        bad_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xaddr_hi.sv
module xaddr_hi #(
  parameter int DW = 32
) (
  input  logic          ext_i,
  input  logic [DW-1:0] hi_q_i,
  input  logic [DW-1:0] dyn_i,
  input  logic [DW-1:0] stat_i,
  output logic [DW-1:0] up_o
);
  always_comb begin
    if (ext_i)              up_o = hi_q_i;
    else if (dyn_i  != '0)  up_o = dyn_i;
    else if (stat_i != '0)  up_o = stat_i;
    else                    up_o = '0;
  end
endmodule

// File: rtl/xaddr_cnt.sv
module xaddr_cnt #(
  parameter int DW    = 32,
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_cnt_i,
  input  logic [DW-1:0]    ld_lo_i,
  input  logic             chunk_i,
  input  logic [CNT_W-1:0] avail_i,
  output logic [CNT_W-1:0] len_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DW-1:0]    lo_o,
  output logic [DW-1:0]    tot_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    lo_q, tot_q;
  logic [DW-1:0]    len_ext;

  assign len_o   = (avail_i < cnt_q) ? avail_i : cnt_q;
  assign len_ext = {{(DW-CNT_W){1'b0}}, len_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lo_q  <= '0;
      tot_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_cnt_i;
      lo_q  <= ld_lo_i;
    end else if (chunk_i) begin
      cnt_q <= cnt_q - len_o;
      lo_q  <= lo_q + len_ext;
      tot_q <= tot_q + len_ext;
    end
  end

  assign cnt_o = cnt_q;
  assign lo_o  = lo_q;
  assign tot_o = tot_q;
endmodule

// File: rtl/dma_xaddr_top.sv
module dma_xaddr_top #(
  parameter int DW    = 32,
  parameter int CNT_W = 24,
  parameter int SCR_N = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [1:0]                     mode_i,
  input  logic                           start_i,
  input  logic                           tbl_ind_i,
  input  logic [xaddr_pkg::ENTRY_W-1:0]  dw0_i,
  input  logic [DW-1:0]                  lo_addr_i,
  input  logic [CNT_W-1:0]               cnt_ld_i,
  input  logic [SCR_N*DW-1:0]            scr_bank_i,
  input  logic [xaddr_pkg::SPC_N*DW-1:0] spc_bank_i,
  input  logic                           chunk_i,
  input  logic [CNT_W-1:0]               avail_i,
  output logic [2*DW-1:0]                dma_addr_o,
  output logic [CNT_W-1:0]               chunk_len_o,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [DW-1:0]                  nxt_addr_o,
  output logic [DW-1:0]                  csbc_o,
  output logic                           done_o,
  output logic                           err_o
);
  import xaddr_pkg::*;

  localparam int TOPB_W = ENTRY_W - CNT_W;

  logic            ext_on, a40_on;
  logic [DW-1:0]   sel_val, hi_q, hi_d, up;
  logic            sel_bad, err_d;
  logic [CNT_W-1:0] ld_cnt;

  assign ext_on = mode_i[0];
  assign a40_on = (xaddr_mode_e'(mode_i) == MODE_A40);

  xaddr_sel #(.DW(DW), .SCR_N(SCR_N)) u_sel (
    .sel_i (dw0_i[CNT_W +: SEL_W]),
    .scr_i (scr_bank_i),
    .spc_i (spc_bank_i),
    .val_o (sel_val),
    .bad_o (sel_bad)
  );

  // 40-bit check must precede the selector path
  always_comb begin
    hi_d  = '0;
    err_d = 1'b0;
    if (tbl_ind_i) begin
      if (a40_on) begin
        hi_d = {{(DW-TOPB_W){1'b0}}, dw0_i[ENTRY_W-1 -: TOPB_W]};
      end else if (ext_on) begin
        hi_d  = sel_bad ? '0 : sel_val;
        err_d = sel_bad;
      end
    end
  end

  assign ld_cnt = tbl_ind_i ? dw0_i[CNT_W-1:0] : cnt_ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      err_o <= 1'b0;
    end else if (start_i) begin
      hi_q  <= hi_d;
      err_o <= err_d;
    end
  end

  xaddr_cnt #(.DW(DW), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (start_i),
    .ld_cnt_i (ld_cnt),
    .ld_lo_i  (lo_addr_i),
    .chunk_i  (chunk_i),
    .avail_i  (avail_i),
    .len_o    (chunk_len_o),
    .cnt_o    (cnt_o),
    .lo_o     (nxt_addr_o),
    .tot_o    (csbc_o)
  );

  xaddr_hi #(.DW(DW)) u_hi (
    .ext_i  (ext_on),
    .hi_q_i (hi_q),
    .dyn_i  (spc_bank_i[SPC_DYN*DW +: DW]),
    .stat_i (spc_bank_i[SPC_STAT*DW +: DW]),
    .up_o   (up)
  );

  assign dma_addr_o = {up, nxt_addr_o};
  assign done_o     = (cnt_o == '0);
endmodule

// File: rtl/xaddr_chk.sv
module xaddr_chk #(
  parameter int DW    = 32,
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             start_i,
  input logic             tbl_ind_i,
  input logic             chunk_i,
  input logic [2*DW-1:0]  dma_addr_o,
  input logic [CNT_W-1:0] chunk_len_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [DW-1:0]    nxt_addr_o,
  input logic [DW-1:0]    csbc_o,
  input logic             done_o,
  input logic             err_o
);
  p_cnt_dec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_i && !start_i |=> cnt_o == $past(cnt_o) - $past(chunk_len_o));

  p_tot_inc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_i && !start_i |=> csbc_o == $past(csbc_o) + DW'($past(chunk_len_o)));

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(nxt_addr_o) && $stable(csbc_o));

  p_err_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !tbl_ind_i |=> !err_o);

  p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && mode_i[0] |-> dma_addr_o[2*DW-1:DW] == '0);

  p_ld_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && chunk_i |=> $stable(csbc_o));

  p_lo_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_addr_o[DW-1:0] == nxt_addr_o);
endmodule

bind dma_xaddr_top xaddr_chk #(.DW(DW), .CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .start_i     (start_i),
  .tbl_ind_i   (tbl_ind_i),
  .chunk_i     (chunk_i),
  .dma_addr_o  (dma_addr_o),
  .chunk_len_o (chunk_len_o),
  .cnt_o       (cnt_o),
  .nxt_addr_o  (nxt_addr_o),
  .csbc_o      (csbc_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/dma_xaddr_top_tb_top.sv
module dma_xaddr_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]   mode = 2'b00;
  logic         start = 1'b0, tbl = 1'b0, chunk = 1'b0;
  logic [31:0]  dw0 = '0, lo_in = '0;
  logic [23:0]  cnt_ld = '0, avail = '0;
  logic [511:0] scr = '0;
  logic [191:0] spc = '0;
  logic [63:0]  dma_addr;
  logic [23:0]  clen, cnt;
  logic [31:0]  nxt, csbc;
  logic         done, err;

  dma_xaddr_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .start_i(start), .tbl_ind_i(tbl),
    .dw0_i(dw0), .lo_addr_i(lo_in), .cnt_ld_i(cnt_ld), .scr_bank_i(scr),
    .spc_bank_i(spc), .chunk_i(chunk), .avail_i(avail), .dma_addr_o(dma_addr),
    .chunk_len_o(clen), .cnt_o(cnt), .nxt_addr_o(nxt), .csbc_o(csbc),
    .done_o(done), .err_o(err)
  );

  typedef struct packed {
    logic [23:0] cnt;
    logic [31:0] lo;
    logic [31:0] tot;
    logic [31:0] up;
    logic        err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_fail = 0;

  logic [23:0] m_cnt = '0;
  logic [31:0] m_lo = '0, m_tot = '0, m_hi = '0;
  logic        m_err = 1'b0;

  function automatic logic [31:0] spc_w(int k);
    return spc[k*32 +: 32];
  endfunction

  function automatic logic [31:0] exp_up();
    if (mode[0])           return m_hi;
    if (spc_w(5) != 0)     return spc_w(5);
    if (spc_w(4) != 0)     return spc_w(4);
    return 32'h0;
  endfunction

  task automatic cmp(string tag, string f, logic [63:0] act, logic [63:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, f, act, ex);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "cnt",  64'(cnt), 64'(e.cnt));
      cmp(t, "lo",   64'(nxt), 64'(e.lo));
      cmp(t, "tot",  64'(csbc), 64'(e.tot));
      cmp(t, "addr", dma_addr, {e.up, e.lo});
      cmp(t, "err",  64'(err), 64'(e.err));
      cmp(t, "done", 64'(done), 64'(e.cnt == 0));
    end
  end

  task automatic push(string tag);
    exp_t e;
    e.cnt = m_cnt; e.lo = m_lo; e.tot = m_tot; e.up = exp_up(); e.err = m_err;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // driver: inputs are set by caller, model updated from requirements
  task automatic step(string tag);
    logic [23:0] len;
    logic [4:0]  sel;
    @(posedge clk);
    #1;
    if (start) begin
      m_cnt = tbl ? dw0[23:0] : cnt_ld;
      m_lo  = lo_in;
      m_hi  = 32'h0;
      m_err = 1'b0;
      if (tbl && mode == 2'b11) begin
        m_hi = {24'h0, dw0[31:24]};
      end else if (tbl && mode[0]) begin
        sel = dw0[28:24];
        if (sel < 16)       m_hi = scr[sel*32 +: 32];
        else if (sel <= 21) m_hi = spc_w(int'(sel) - 16);
        else                m_err = 1'b1;
      end
    end else if (chunk) begin
      len   = (avail < m_cnt) ? avail : m_cnt;
      m_cnt = m_cnt - len;
      m_lo  = m_lo + {8'h0, len};
      m_tot = m_tot + {8'h0, len};
    end
    start = 1'b0;
    chunk = 1'b0;
    push(tag);
    @(negedge clk);
    #1;
  endtask

  task automatic load(logic t, logic [31:0] d, logic [23:0] c, logic [31:0] l, string tag);
    start = 1'b1; tbl = t; dw0 = d; cnt_ld = c; lo_in = l;
    step(tag);
  endtask

  task automatic move(logic [23:0] a, string tag);
    chunk = 1'b1; avail = a;
    step(tag);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) scr[k*32 +: 32] = 32'h1000 + k * 32'h111;
    for (int k = 0; k < 4; k++)  spc[k*32 +: 32] = 32'hA0 + k;
    #1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    push("R1 reset");
    @(negedge clk); #1;

    load(1'b0, 32'h0, 24'd100, 32'h1000, "R2 R7 plain load");
    move(24'd30, "R10 partial chunk");
    move(24'd200, "R10 clipped chunk");
    move(24'd5, "R11 chunk at zero");
    spc[4*32 +: 32] = 32'h55;
    step("R9 static word");
    spc[5*32 +: 32] = 32'h77;
    step("R9 dynamic over static");
    spc[4*32 +: 32] = 32'h0;
    spc[5*32 +: 32] = 32'h0;
    step("R9 chain zero");

    mode = 2'b11;
    load(1'b1, 32'hFF000040, 24'd0, 32'h2000, "R3 40-bit top byte");
    move(24'h40, "R10 exact chunk");
    mode = 2'b01;
    load(1'b1, 32'h03000010, 24'd0, 32'h3000, "R4 scratch 3");
    load(1'b1, 32'h0F000008, 24'd0, 32'h3100, "R4 scratch 15");
    spc[4*32 +: 32] = 32'h44;
    spc[5*32 +: 32] = 32'h66;
    load(1'b1, 32'h10000008, 24'd0, 32'h3200, "R5 special 0");
    load(1'b1, 32'h14000008, 24'd0, 32'h3200, "R5 static word");
    load(1'b1, 32'h15000008, 24'd0, 32'h3300, "R5 dynamic word");
    mode = 2'b00;
    step("R8 mode off uses chain");
    mode = 2'b01;
    step("R8 mode on uses latched");
    load(1'b1, 32'h16000004, 24'd0, 32'h3400, "R6 selector 22");
    move(24'd1, "R6 error holds");
    load(1'b1, 32'h1F000004, 24'd0, 32'h3500, "R6 selector 31");
    load(1'b1, 32'h02000004, 24'd0, 32'h3600, "R6 cleared by load");
    load(1'b1, 32'h16000004, 24'd0, 32'h3700, "R6 error again");
    load(1'b0, 32'h0, 24'd9, 32'h3800, "R7 plain load clears");
    mode = 2'b10;
    load(1'b1, 32'h05000020, 24'd0, 32'h3900, "R7 timing only no latch");
    mode = 2'b01;
    step("R8 latched zero");
    start = 1'b1; tbl = 1'b0; cnt_ld = 24'd50; lo_in = 32'h4000;
    chunk = 1'b1; avail = 24'd10;
    step("R12 load beats chunk");
    move(24'd10, "R12 follow-up chunk");
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule